// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets processors on one chip hand each other short, fixed-size messages. It holds a set of one-way channels, each with a 64-byte register window. A sender claims a free channel by writing a single owner bit, fills eight message words, chooses which remote interrupt lines to raise, and then fires the transfer. The selected lines stay asserted until someone clears them. The channel reports its progress through a mode register: idle, then busy, then acknowledged. In automatic mode the acknowledge follows by itself one cycle after the send. In manual mode it waits for an explicit acknowledge write.

A single global guard word sits above the channel windows. Until the correct key is written to it, every channel access is blocked. The host bus is a simple word-addressed read/write port. Read data appears one cycle after the read strobe.

Top module: `ipc_mbox`

## Requirements
- R1: After reset the guard is engaged (address 0xA00 reads 1), `irq_out` is all zero, and every channel is idle: mode reads 0x10, source reads 0, and the interrupt mask reads all ones.
- R2: Writing 0x1ACCE551 to address 0xA00 releases the guard, and that address then reads 0. Writing any other value there engages the guard again, and it reads 1.
- R3: While the guard is engaged, writes to channel windows change nothing and reads of channel windows return 0.
- R4: A write to the source register (offset 0x00) stores the value only if the channel is idle, its source is zero and the value has exactly one bit set. Every other source write is ignored, apart from the release in R10.
- R5: The eight message words at offsets 0x20, 0x24, … 0x3C store and read back independently.
- R6: Writing the stored source value to the send register (offset 0x1C) of an idle, claimed channel makes it busy. In the same step the status register (0x0C) ORs in destination (0x04) AND NOT mask (0x14). `irq_out` is the OR of the status registers of all channels. A send with any other value, or on an unclaimed channel, is ignored.
- R7: In the mode register (0x10), bit 0 is the automatic-acknowledge setting, bit 4 reads 1 when idle, and bit 7 reads 1 when acknowledged. With bit 0 set, a busy channel becomes acknowledged on the next cycle.
- R8: With bit 0 clear, a busy channel stays busy until a nonzero write to the acknowledge register (offset 0x18).
- R9: Writing a value to the status-clear register (offset 0x08) clears the matching status bits, and `irq_out` drops with them.
- R10: Writing the stored source value to the source register of an acknowledged channel returns the channel to idle with source 0. The same write while the channel is busy is ignored.
- R11: Channel n occupies byte addresses n·0x40 to n·0x40+0x3F. Read data is registered and is valid in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 32 | Interrupt lines toward remote processors |

## Verification
Some properties are checked by assertions on every cycle. A claimed source is always one-hot. A channel that is busy or acknowledged always has an owner. A busy channel in automatic mode is acknowledged on the next cycle. Reads while the guard is engaged return zero. Writing the key always opens the guard on the next cycle.

Other behaviour can only be shown by the bench scenarios. These include the one-cycle busy window that a read sees right after a send, the masking of destination bits, claims and releases being ignored in the wrong state, and channel contents surviving writes made while the guard was engaged. A behavioural model checks `irq_out` and every read on every clock.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 8;
    localparam int MSG_IDX_W = $clog2(MSG_WORDS);

    localparam logic [WORD_W-1:0] GUARD_KEY = 32'h1ACC_E551;

    localparam int MODE_AUTO_BIT = 0;
    localparam int MODE_IDLE_BIT = 4;
    localparam int MODE_ACK_BIT  = 7;

    // word offsets inside one channel window (byte offset / 4)
    localparam logic [3:0] W_OWNER  = 4'd0;
    localparam logic [3:0] W_TARGET = 4'd1;
    localparam logic [3:0] W_TCLR   = 4'd2;
    localparam logic [3:0] W_TSTAT  = 4'd3;
    localparam logic [3:0] W_MODE   = 4'd4;
    localparam logic [3:0] W_MASK   = 4'd5;
    localparam logic [3:0] W_ACKW   = 4'd6;
    localparam logic [3:0] W_FIRE   = 4'd7;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_BUSY  = 2'd1,
        CH_ACKED = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic              wr;
        logic [3:0]        word;
        logic [WORD_W-1:0] wdata;
    } ch_req_t;

    function automatic logic single_bit(input logic [WORD_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [WORD_W-1:0] mode_view(input ch_state_e s, input logic auto_ack);
        logic [WORD_W-1:0] m;
        m = '0;
        m[MODE_AUTO_BIT] = auto_ack;
        m[MODE_IDLE_BIT] = (s == CH_IDLE);
        m[MODE_ACK_BIT]  = (s == CH_ACKED);
        return m;
    endfunction

endpackage

// File: rtl/ipc_mbox_guard.sv
module ipc_mbox_guard
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    output logic              open_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
        end else if (wr && sel) begin
            open_o <= (wdata == GUARD_KEY);
        end
    end

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel && wdata == GUARD_KEY) |=> open_o);

    // R2
    other_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel && wdata != GUARD_KEY) |=> !open_o);

endmodule

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
    import ipc_mbox_pkg::*;
#(
    parameter int IRQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_req_t           req,
    output logic [WORD_W-1:0] rd_val,
    output logic [IRQ_W-1:0]  irq_vec
);

    ch_state_e         state_q;
    logic [WORD_W-1:0] owner_q;
    logic [IRQ_W-1:0]  target_q;
    logic [IRQ_W-1:0]  tstat_q;
    logic [IRQ_W-1:0]  mask_q;
    logic              auto_q;
    logic [WORD_W-1:0] msg_q [MSG_WORDS];

    logic [MSG_IDX_W-1:0] msg_idx;
    assign msg_idx = req.word[MSG_IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CH_IDLE;
            owner_q  <= '0;
            target_q <= '0;
            tstat_q  <= '0;
            mask_q   <= '1;
            auto_q   <= 1'b0;
            for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= '0;
        end else begin
            if (state_q == CH_BUSY && auto_q) state_q <= CH_ACKED;
            if (req.wr) begin
                case (req.word)
                    W_OWNER: begin
                        if (state_q == CH_IDLE && owner_q == '0 && single_bit(req.wdata))
                            owner_q <= req.wdata;
                        else if (state_q == CH_ACKED && owner_q != '0 && req.wdata == owner_q) begin
                            owner_q <= '0;
                            state_q <= CH_IDLE;
                        end
                    end
                    W_TARGET: target_q <= req.wdata[IRQ_W-1:0];
                    W_TCLR:   tstat_q  <= tstat_q & ~req.wdata[IRQ_W-1:0];
                    W_MODE:   auto_q   <= req.wdata[MODE_AUTO_BIT];
                    W_MASK:   mask_q   <= req.wdata[IRQ_W-1:0];
                    W_ACKW: begin
                        if (state_q == CH_BUSY && req.wdata != '0) state_q <= CH_ACKED;
                    end
                    W_FIRE: begin
                        if (state_q == CH_IDLE && owner_q != '0 && req.wdata == owner_q) begin
                            state_q <= CH_BUSY;
                            tstat_q <= tstat_q | (target_q & ~mask_q);
                        end
                    end
                    default: begin
                        if (req.word[3]) msg_q[msg_idx] <= req.wdata;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (req.word)
            W_OWNER:  rd_val = owner_q;
            W_TARGET: rd_val[IRQ_W-1:0] = target_q;
            W_TSTAT:  rd_val[IRQ_W-1:0] = tstat_q;
            W_MODE:   rd_val = mode_view(state_q, auto_q);
            W_MASK:   rd_val[IRQ_W-1:0] = mask_q;
            default:  if (req.word[3]) rd_val = msg_q[msg_idx];
        endcase
    end

    assign irq_vec = tstat_q;

    // R4
    owner_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner_q));

    // R6
    active_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != CH_IDLE) |-> (owner_q != '0));

    // R7
    auto_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_BUSY && auto_q) |=> (state_q == CH_ACKED));

    // R10
    idle_from_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_IDLE && $past(state_q) != CH_IDLE && !$past(rst)) |-> ($past(state_q) == CH_ACKED));

endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
    import ipc_mbox_pkg::*;
#(
    parameter int              NUM_CH     = 32,
    parameter int              IRQ_W      = 32,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 12'hA00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [IRQ_W-1:0]  irq_out
);

    localparam int WIN_SHIFT  = 6;
    localparam int CH_FIELD_W = ADDR_W - WIN_SHIFT;
    localparam int CH_SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [CH_FIELD_W-1:0] NUM_CH_V = CH_FIELD_W'(NUM_CH);

    logic                  guard_open;
    logic                  guard_hit;
    logic                  ch_hit;
    logic [CH_FIELD_W-1:0] ch_field;
    logic [CH_SEL_W-1:0]   ch_sel;
    logic [WORD_W-1:0]     ch_rd  [NUM_CH];
    logic [IRQ_W-1:0]      ch_irq [NUM_CH];

    assign guard_hit = (bus_addr == GUARD_ADDR);
    assign ch_field  = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign ch_sel    = bus_addr[WIN_SHIFT +: CH_SEL_W];
    assign ch_hit    = (ch_field < NUM_CH_V) && (bus_addr[1:0] == 2'b00);

    ipc_mbox_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .sel    (guard_hit),
        .wdata  (bus_wdata),
        .open_o (guard_open)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_req_t req;
        assign req.wr    = bus_wr && guard_open && ch_hit && (ch_sel == CH_SEL_W'(g));
        assign req.word  = bus_addr[5:2];
        assign req.wdata = bus_wdata;

        ipc_mbox_chan #(.IRQ_W(IRQ_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .rd_val  (ch_rd[g]),
            .irq_vec (ch_irq[g])
        );
    end

    always_comb begin
        irq_out = '0;
        for (int i = 0; i < NUM_CH; i++) irq_out = irq_out | ch_irq[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (guard_hit)
                bus_rdata <= {{(WORD_W-1){1'b0}}, !guard_open};
            else if (ch_hit && guard_open)
                bus_rdata <= ch_rd[ch_sel];
            else
                bus_rdata <= '0;
        end
    end

    // R3
    closed_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !guard_open && !guard_hit) |=> (bus_rdata == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq_out == '0));

endmodule

// File: tb/ipc_mbox_tb.sv
`timescale 1ns/1ps
module ipc_mbox_tb;

    localparam logic [31:0] KEY = 32'h1ACC_E551;
    localparam logic [11:0] GA  = 12'hA00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipc_mbox u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_locked;
    logic [31:0] m_src   [32];
    logic [31:0] m_dst   [32];
    logic [31:0] m_dstat [32];
    logic [31:0] m_mask  [32];
    logic [31:0] m_data  [32][8];
    bit          m_auto  [32];
    int          m_st    [32];   // 0 idle, 1 busy, 2 acked
    logic [31:0] exp_rd;
    bit          rd_pend;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int c;
        int w;
        if (a == GA) return {31'b0, m_locked};
        if (m_locked || a[1:0] != 2'b00 || a[11:6] >= 6'd32) return 32'h0;
        c = int'(a[11:6]);
        w = int'(a[5:2]);
        case (w)
            0: return m_src[c];
            1: return m_dst[c];
            3: return m_dstat[c];
            4: return {24'b0, (m_st[c] == 2), 2'b0, (m_st[c] == 0), 3'b0, m_auto[c]};
            5: return m_mask[c];
            2, 6, 7: return 32'h0;
            default: return m_data[c][w-8];
        endcase
    endfunction

    always @(posedge clk) begin
        int os [32];
        bit oa [32];
        if (rst) begin
            m_locked = 1'b1;
            rd_pend  = 1'b0;
            for (int c = 0; c < 32; c++) begin
                m_src[c] = 0; m_dst[c] = 0; m_dstat[c] = 0; m_mask[c] = '1;
                m_auto[c] = 0; m_st[c] = 0;
                for (int k = 0; k < 8; k++) m_data[c][k] = 0;
            end
        end else begin
            rd_pend = bus_rd;
            if (bus_rd) exp_rd = m_read(bus_addr);
            for (int c = 0; c < 32; c++) begin os[c] = m_st[c]; oa[c] = m_auto[c]; end
            if (bus_wr) begin
                if (bus_addr == GA) begin
                    m_locked = (bus_wdata != KEY);
                end else if (!m_locked && bus_addr[1:0] == 2'b00 && bus_addr[11:6] < 6'd32) begin
                    automatic int c = int'(bus_addr[11:6]);
                    automatic int w = int'(bus_addr[5:2]);
                    case (w)
                        0: begin
                            if (m_st[c] == 0 && m_src[c] == 0 && $onehot(bus_wdata)) m_src[c] = bus_wdata;
                            else if (m_st[c] == 2 && m_src[c] != 0 && bus_wdata == m_src[c]) begin
                                m_src[c] = 0; m_st[c] = 0;
                            end
                        end
                        1: m_dst[c] = bus_wdata;
                        2: m_dstat[c] = m_dstat[c] & ~bus_wdata;
                        3: ;
                        4: m_auto[c] = bus_wdata[0];
                        5: m_mask[c] = bus_wdata;
                        6: if (m_st[c] == 1 && bus_wdata != 0) m_st[c] = 2;
                        7: if (m_st[c] == 0 && m_src[c] != 0 && bus_wdata == m_src[c]) begin
                            m_st[c] = 1;
                            m_dstat[c] = m_dstat[c] | (m_dst[c] & ~m_mask[c]);
                        end
                        default: m_data[c][w-8] = bus_wdata;
                    endcase
                end
            end
            for (int c = 0; c < 32; c++)
                if (os[c] == 1 && oa[c] && m_st[c] == 1) m_st[c] = 2;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        logic [31:0] mirq;
        if (!rst && !done) begin
            mirq = 0;
            for (int c = 0; c < 32; c++) mirq = mirq | m_dstat[c];
            compared++;
            if (irq_out !== mirq) begin
                mismatched++;
                $display("FAIL R6 model irq_out actual=%h expected=%h", irq_out, mirq);
            end
            if (rd_pend) begin
                compared++;
                if (bus_rdata !== exp_rd) begin
                    mismatched++;
                    $display("FAIL R11 model read addr=%h actual=%h expected=%h", bus_addr, bus_rdata, exp_rd);
                end
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called and returns at a negedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // R11: data registered at the edge after the strobe, sampled at the next negedge
    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata, exp, tag);
    endtask

    localparam logic [11:0] C3  = 12'h0C0;
    localparam logic [11:0] C31 = 12'h7C0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(irq_out, 32'h0, "R1 irq after reset");
        rd(GA, 32'h1, "R1 guard engaged");
        // R3 locked access
        rd(C3 + 12'h10, 32'h0, "R3 locked read");
        wr(C3 + 12'h20, 32'h1234_5678);
        // R2 unlock
        wr(GA, KEY);
        rd(GA, 32'h0, "R2 guard open");
        rd(C3 + 12'h20, 32'h0, "R3 locked write ignored");
        rd(C3 + 12'h10, 32'h10, "R1 mode idle");
        rd(C3 + 12'h14, 32'hFFFF_FFFF, "R1 mask all ones");
        rd(C3 + 12'h00, 32'h0, "R1 source zero");

        // R4 claim
        wr(C3, 32'h20);
        rd(C3, 32'h20, "R4 claim read back");
        wr(C3, 32'h40);
        rd(C3, 32'h20, "R4 second claim ignored");
        wr(C31, 32'h3);
        rd(C31, 32'h0, "R4 multi-bit claim ignored");

        // R5 message words
        for (int i = 0; i < 8; i++) wr(C3 + 12'h20 + 12'(4*i), 32'hA5A5_0000 + 32'(i*17));
        for (int i = 0; i < 8; i++) rd(C3 + 12'h20 + 12'(4*i), 32'hA5A5_0000 + 32'(i*17), "R5 data word");

        // R6/R7 send in automatic mode
        wr(C3 + 12'h04, 32'h0000_0104);
        wr(C3 + 12'h14, 32'hFFFF_FFFB);
        wr(C3 + 12'h10, 32'h1);
        wr(C3 + 12'h1C, 32'h40);
        rd(C3 + 12'h10, 32'h11, "R6 wrong send bit ignored");
        wr(C3 + 12'h1C, 32'h20);
        rd(C3 + 12'h10, 32'h01, "R7 busy for one cycle");
        rd(C3 + 12'h10, 32'h81, "R7 auto acknowledged");
        rd(C3 + 12'h0C, 32'h4, "R6 status masked");
        chk(irq_out, 32'h4, "R6 irq_out raised");

        // R9 clear
        wr(C3 + 12'h08, 32'h4);
        rd(C3 + 12'h0C, 32'h0, "R9 status cleared");
        chk(irq_out, 32'h0, "R9 irq_out dropped");

        // R10 release
        wr(C3, 32'h20);
        rd(C3 + 12'h10, 32'h11, "R10 back to idle");
        rd(C3, 32'h0, "R10 source cleared");

        // R8 manual mode on channel 31
        wr(C31, 32'h1);
        wr(C31 + 12'h14, 32'h0);
        wr(C31 + 12'h04, 32'h8000_0001);
        wr(C31 + 12'h1C, 32'h1);
        rd(C31 + 12'h10, 32'h00, "R8 busy");
        rd(C31 + 12'h10, 32'h00, "R8 still busy");
        chk(irq_out, 32'h8000_0001, "R6 irq_out both lines");
        wr(C31, 32'h1);
        rd(C31, 32'h1, "R10 release ignored while busy");
        wr(C31 + 12'h18, 32'h1);
        rd(C31 + 12'h10, 32'h80, "R8 manual acknowledge");
        wr(C31, 32'h1);
        rd(C31 + 12'h10, 32'h10, "R10 manual channel idle");

        // R2 relock and R3 preservation
        wr(GA, 32'h0);
        rd(GA, 32'h1, "R2 relocked");
        rd(C3 + 12'h20, 32'h0, "R3 locked read zero");
        wr(C3 + 12'h20, 32'hDEAD_BEEF);
        wr(C31 + 12'h08, 32'hFFFF_FFFF);
        chk(irq_out, 32'h8000_0001, "R3 locked clear ignored");
        wr(GA, KEY);
        rd(C3 + 12'h20, 32'hA5A5_0000, "R3 data kept");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule